// File: doc/BRIEF.md
# SPI Slave Hold-Mode Controller

This block sits between the pins of a serial flash slave and its shift datapath and command engine. It brings the active-low hold input, the active-low chip select, the serial clock and the serial data input into a fast system clock domain. From them it decides when serial traffic is paused. While the pause lasts, the shift datapath sees no clock events and no data, and the serial output driver is turned off. A program, erase or status-write operation that is already running inside the device is untouched, because this block has no path to that engine.

Whether entry into or exit from the pause takes effect at once depends on the serial clock level at the moment the hold input changes. If the serial clock is low, the change takes effect directly. If it is high, the change waits for the next falling serial clock edge. If chip select rises during a pause, the block emits a one-cycle interface reset pulse that clears the bit counter and the command state downstream. Hold is only entered on a falling hold edge seen while the device is selected. A hold input that is already low when chip select falls therefore does not start a pause.

Top module: `spi_hold_ctrl`

## Requirements
- R1: With chip select low, a falling hold input seen while the synchronized serial clock is low makes `hold_active` high at once, that is, on the state update that follows detection of the edge.
- R2: With chip select low, a falling hold input seen while the serial clock is high leaves `hold_active` low until the next falling serial clock edge. At that edge it goes high. That falling edge is still forwarded as a `shift_fall` pulse.
- R3: A rising hold input seen while the serial clock is low ends the pause at once, and `hold_active` returns to 0.
- R4: A rising hold input seen while the serial clock is high keeps `hold_active` high until the next falling serial clock edge. That edge ends the pause and is not forwarded as a `shift_fall` pulse.
- R5: While `hold_active` is 1, `shift_en`, `shift_rise`, `shift_fall` and `so_oe` are 0. `si_gated` is 0 under the default parameter setting (`SI_HOLD_LAST` = 0).
- R6: A rising chip select seen while `hold_active` is 1 produces exactly one cycle of `if_reset` = 1. `hold_active` is 0 from the next cycle on.
- R7: While chip select is high, `hold_active` is 0. A pending entry is discarded, and hold-input edges have no effect.
- R8: A hold input that is already low when chip select falls does not start a pause, and serial clock edges are forwarded.
- R9: With chip select low and no pause, each synchronized rising or falling serial clock edge gives one cycle of `shift_rise` or `shift_fall`. `si_gated` follows the synchronized data input, `so_oe` follows `so_req`, and `shift_en` is 1.
- R10: After reset, `hold_active`, `shift_en`, `shift_rise`, `shift_fall`, `si_gated`, `so_oe` and `if_reset` are all 0. Chip select and hold are taken as high, and the serial clock as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_n_pin | input | 1 | Active-low hold pin, asynchronous |
| cs_n_pin | input | 1 | Active-low chip select pin, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| si_pin | input | 1 | Serial data input pin, asynchronous |
| so_req | input | 1 | Shift datapath request to drive the serial output |
| hold_active | output | 1 | Pause in effect |
| shift_en | output | 1 | Gated enable for the shift logic |
| shift_rise | output | 1 | One-cycle pulse per forwarded rising serial clock edge |
| shift_fall | output | 1 | One-cycle pulse per forwarded falling serial clock edge |
| si_gated | output | 1 | Serial data as seen by the shift logic |
| so_oe | output | 1 | Output-enable for the serial data output driver |
| if_reset | output | 1 | One-cycle interface reset pulse |

## Verification
A pin change made between two clock edges is captured by the first synchronizer flop at the next edge. It becomes the synchronized value one edge later. The hold state reflects it at the third edge, and `if_reset` together with the shift pulses are already visible in the cycle before that third edge. The bench model carries the same three-edge delay in its own pin history arrays and compares all seven outputs at every falling clock edge, half a period away from the edge where the design updates. The named spot checks wait six cycles after each stimulus, so that every delayed result has settled before they sample. Pulse results are counted over a whole window instead of being sampled at a single cycle.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   typedef enum logic [1:0] {
      HS_IDLE     = 2'd0,
      HS_WAIT_IN  = 2'd1,
      HS_HELD     = 2'd2,
      HS_WAIT_OUT = 2'd3
   } hold_state_t;

   localparam int PIN_W    = 4;
   localparam int IDX_HOLD = 0;
   localparam int IDX_CS   = 1;
   localparam int IDX_SCK  = 2;
   localparam int IDX_SI   = 3;
   // idle levels: hold high, cs high, sck low, si low
   localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0011;
endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
   parameter int               W       = 4,
   parameter int               STAGES  = 2,
   parameter logic [W-1:0]     RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_hold_edge.sv
module spi_hold_edge #(
   parameter int           W       = 4,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cur,
   output logic [W-1:0] prev,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= cur;
   end

   assign rise = cur & ~prev;
   assign fall = prev & ~cur;
endmodule

// File: rtl/spi_hold_fsm.sv
module spi_hold_fsm
   import spi_hold_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        deselect,
   input  logic        hold_fall,
   input  logic        hold_rise,
   input  logic        sck_lvl,
   input  logic        sck_fall,
   output hold_state_t state
);
   hold_state_t nxt;

   always_comb begin
      nxt = state;
      if (deselect) begin
         nxt = HS_IDLE;
      end else begin
         unique case (state)
            HS_IDLE:
               if (hold_fall) nxt = sck_lvl ? HS_WAIT_IN : HS_HELD;
            HS_WAIT_IN:
               if (hold_rise)     nxt = HS_IDLE;
               else if (sck_fall) nxt = HS_HELD;
            HS_HELD:
               if (hold_rise) nxt = sck_lvl ? HS_WAIT_OUT : HS_IDLE;
            HS_WAIT_OUT:
               if (hold_fall)     nxt = HS_HELD;
               else if (sck_fall) nxt = HS_IDLE;
            default: nxt = HS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= HS_IDLE;
      else        state <= nxt;
   end
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
   import spi_hold_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter bit SI_HOLD_LAST = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_n_pin,
   input  logic cs_n_pin,
   input  logic sck_pin,
   input  logic si_pin,
   input  logic so_req,
   output logic hold_active,
   output logic shift_en,
   output logic shift_rise,
   output logic shift_fall,
   output logic si_gated,
   output logic so_oe,
   output logic if_reset
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("spi_hold_ctrl: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [PIN_W-1:0] pins_raw, pins_q, pins_p, pins_rise, pins_fall;
   hold_state_t      state;

   assign pins_raw[IDX_HOLD] = hold_n_pin;
   assign pins_raw[IDX_CS]   = cs_n_pin;
   assign pins_raw[IDX_SCK]  = sck_pin;
   assign pins_raw[IDX_SI]   = si_pin;

   spi_hold_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pins_raw), .q(pins_q)
   );

   spi_hold_edge #(.W(PIN_W), .RST_VAL(PIN_IDLE)) u_edge (
      .clk(clk), .rst_n(rst_n), .cur(pins_q), .prev(pins_p),
      .rise(pins_rise), .fall(pins_fall)
   );

   logic hold_q, cs_q, sck_q, si_q;
   assign hold_q = pins_q[IDX_HOLD];
   assign cs_q   = pins_q[IDX_CS];
   assign sck_q  = pins_q[IDX_SCK];
   assign si_q   = pins_q[IDX_SI];

   spi_hold_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .deselect(cs_q),
      .hold_fall(pins_fall[IDX_HOLD]),
      .hold_rise(pins_rise[IDX_HOLD]),
      .sck_lvl(sck_q),
      .sck_fall(pins_fall[IDX_SCK]),
      .state(state)
   );

   assign hold_active = (state == HS_HELD) || (state == HS_WAIT_OUT);
   assign shift_en    = !hold_active && !cs_q;
   assign shift_rise  = shift_en && pins_rise[IDX_SCK];
   assign shift_fall  = shift_en && pins_fall[IDX_SCK];
   assign so_oe       = shift_en && so_req;
   assign if_reset    = hold_active && pins_rise[IDX_CS];

   generate
      if (SI_HOLD_LAST) begin : g_si_keep
         logic si_keep;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        si_keep <= 1'b0;
            else if (shift_en) si_keep <= si_q;
         end
         assign si_gated = shift_en ? si_q : si_keep;
      end else begin : g_si_zero
         assign si_gated = shift_en && si_q;
      end
   endgenerate
endmodule

// File: rtl/spi_hold_chk.sv
module spi_hold_chk (
   input logic clk,
   input logic rst_n,
   input logic hold_q,
   input logic cs_q,
   input logic hold_active,
   input logic shift_en,
   input logic shift_rise,
   input logic shift_fall,
   input logic so_oe,
   input logic if_reset
);
   assert_quiet_in_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hold_active |-> (!shift_en && !shift_rise && !shift_fall && !so_oe));

   assert_deselect_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q |=> !hold_active);

   assert_reset_only_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      if_reset |-> hold_active);

   assert_reset_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      if_reset |=> (!if_reset && !hold_active));

   assert_entry_needs_low_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hold_active) |-> $past(!hold_q));

   assert_exit_needs_high_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_active) |-> ($past(hold_q) || $past(cs_q)));
endmodule

bind spi_hold_ctrl spi_hold_chk u_chk (
   .clk(clk), .rst_n(rst_n), .hold_q(hold_q), .cs_q(cs_q),
   .hold_active(hold_active), .shift_en(shift_en), .shift_rise(shift_rise),
   .shift_fall(shift_fall), .so_oe(so_oe), .if_reset(if_reset)
);

// File: tb/tb_spi_hold_ctrl.sv
module tb_spi_hold_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold_n_pin = 1'b1, cs_n_pin = 1'b1, sck_pin = 1'b0, si_pin = 1'b0, so_req = 1'b0;
   logic hold_active, shift_en, shift_rise, shift_fall, si_gated, so_oe, if_reset;

   always #10 clk = ~clk;

   spi_hold_ctrl dut (
      .clk(clk), .rst_n(rst_n), .hold_n_pin(hold_n_pin), .cs_n_pin(cs_n_pin),
      .sck_pin(sck_pin), .si_pin(si_pin), .so_req(so_req),
      .hold_active(hold_active), .shift_en(shift_en), .shift_rise(shift_rise),
      .shift_fall(shift_fall), .si_gated(si_gated), .so_oe(so_oe), .if_reset(if_reset)
   );

   int n_tests = 0, n_fail = 0;
   string phase = "R10";
   bit comparing = 1'b0;
   int cnt_rise = 0, cnt_fall = 0, cnt_rst = 0;

   // reference model: pin histories [0]=first capture, [1]=synchronized, [2]=previous
   int h_hold[3], h_cs[3], h_sck[3], h_si[3];
   int mode; // 0 idle, 1 waiting to enter, 2 held, 3 waiting to leave

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin
            h_hold[i] = 1; h_cs[i] = 1; h_sck[i] = 0; h_si[i] = 0;
         end
         mode = 0;
      end else begin
         bit hf, hr, sf;
         hf = (h_hold[2] == 1) && (h_hold[1] == 0);
         hr = (h_hold[2] == 0) && (h_hold[1] == 1);
         sf = (h_sck[2] == 1) && (h_sck[1] == 0);
         if (h_cs[1] == 1)                 mode = 0;
         else if (mode == 0 && hf)         mode = (h_sck[1] == 1) ? 1 : 2;
         else if (mode == 1 && hr)         mode = 0;
         else if (mode == 1 && sf)         mode = 2;
         else if (mode == 2 && hr)         mode = (h_sck[1] == 1) ? 3 : 0;
         else if (mode == 3 && hf)         mode = 2;
         else if (mode == 3 && sf)         mode = 0;
         h_hold[2] = h_hold[1]; h_cs[2] = h_cs[1]; h_sck[2] = h_sck[1]; h_si[2] = h_si[1];
         h_hold[1] = h_hold[0]; h_cs[1] = h_cs[0]; h_sck[1] = h_sck[0]; h_si[1] = h_si[0];
         h_hold[0] = hold_n_pin; h_cs[0] = cs_n_pin; h_sck[0] = sck_pin; h_si[0] = si_pin;
      end
   end

   task automatic check(string req, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         cnt_rise += shift_rise;
         cnt_fall += shift_fall;
         cnt_rst  += if_reset;
      end
      if (rst_n && comparing) begin
         int e_held, e_en, e_r, e_f, e_si, e_oe, e_rst;
         e_held = (mode == 2 || mode == 3);
         e_en   = !e_held && (h_cs[1] == 0);
         e_r    = e_en && h_sck[1] == 1 && h_sck[2] == 0;
         e_f    = e_en && h_sck[1] == 0 && h_sck[2] == 1;
         e_si   = e_en && h_si[1] == 1;
         e_oe   = e_en && so_req;
         e_rst  = e_held && h_cs[1] == 1 && h_cs[2] == 0;
         check(phase, "outputs {held,en,rise,fall,si,oe,rst}",
               {25'd0, hold_active, shift_en, shift_rise, shift_fall, si_gated, so_oe, if_reset},
               (e_held << 6) | (e_en << 5) | (e_r << 4) | (e_f << 3) | (e_si << 2) | (e_oe << 1) | e_rst);
      end
   end

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic clr_cnt();
      cnt_rise = 0; cnt_fall = 0; cnt_rst = 0;
   endtask

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      // R10 reset state
      check("R10", "hold_active", hold_active, 0);
      check("R10", "shift_en", shift_en, 0);
      check("R10", "so_oe/if_reset/si", {so_oe, if_reset, si_gated}, 0);
      rst_n = 1'b1;
      wait_cyc(2);
      comparing = 1'b1;

      // R9 normal forwarding
      phase = "R9";
      cs_n_pin = 1'b0; so_req = 1'b1; wait_cyc(6);
      check("R9", "shift_en", shift_en, 1);
      check("R9", "so_oe", so_oe, 1);
      clr_cnt();
      for (int k = 0; k < 4; k++) begin
         si_pin = k[0]; sck_pin = 1'b1; wait_cyc(4);
         sck_pin = 1'b0; wait_cyc(4);
      end
      wait_cyc(4);
      check("R9", "rise pulses", cnt_rise, 4);
      check("R9", "fall pulses", cnt_fall, 4);
      si_pin = 1'b1; wait_cyc(6);
      check("R9", "si_gated", si_gated, 1);

      // R1 immediate entry with sck low, R5 gating
      phase = "R1";
      hold_n_pin = 1'b0; wait_cyc(6);
      check("R1", "hold_active", hold_active, 1);
      phase = "R5";
      check("R5", "si_gated", si_gated, 0);
      check("R5", "so_oe", so_oe, 0);
      clr_cnt();
      for (int k = 0; k < 3; k++) begin
         sck_pin = 1'b1; wait_cyc(4); sck_pin = 1'b0; wait_cyc(4);
      end
      wait_cyc(4);
      check("R5", "pulses in hold", cnt_rise + cnt_fall, 0);

      // R3 immediate exit with sck low
      phase = "R3";
      hold_n_pin = 1'b1; wait_cyc(6);
      check("R3", "hold_active", hold_active, 0);

      // R2 deferred entry with sck high
      phase = "R2";
      sck_pin = 1'b1; wait_cyc(6);
      hold_n_pin = 1'b0; wait_cyc(6);
      check("R2", "hold_active pending", hold_active, 0);
      clr_cnt();
      sck_pin = 1'b0; wait_cyc(6);
      check("R2", "hold_active entered", hold_active, 1);
      check("R2", "entering fall forwarded", cnt_fall, 1);

      // R4 deferred exit with sck high
      phase = "R4";
      sck_pin = 1'b1; wait_cyc(6);
      hold_n_pin = 1'b1; wait_cyc(6);
      check("R4", "hold_active pending exit", hold_active, 1);
      clr_cnt();
      sck_pin = 1'b0; wait_cyc(6);
      check("R4", "hold_active exited", hold_active, 0);
      check("R4", "exiting fall suppressed", cnt_fall, 0);

      // R6 chip select rises during hold
      phase = "R6";
      hold_n_pin = 1'b0; wait_cyc(6);
      check("R6", "hold_active before", hold_active, 1);
      clr_cnt();
      cs_n_pin = 1'b1; wait_cyc(6);
      check("R6", "if_reset pulses", cnt_rst, 1);
      check("R6", "hold_active after", hold_active, 0);

      // R7 deselected: hold edges ignored, pending entry discarded
      phase = "R7";
      hold_n_pin = 1'b1; wait_cyc(6);
      sck_pin = 1'b1; wait_cyc(4);
      hold_n_pin = 1'b0; wait_cyc(4);
      sck_pin = 1'b0; wait_cyc(6);
      check("R7", "hold_active deselected", hold_active, 0);
      hold_n_pin = 1'b1; wait_cyc(4);
      cs_n_pin = 1'b0; wait_cyc(4);
      sck_pin = 1'b1; wait_cyc(4);
      hold_n_pin = 1'b0; wait_cyc(6);
      cs_n_pin = 1'b1; wait_cyc(6);
      cs_n_pin = 1'b0; wait_cyc(4);
      sck_pin = 1'b0; wait_cyc(6);
      check("R7", "pending entry discarded", hold_active, 0);

      // R8 hold already low at selection
      phase = "R8";
      cs_n_pin = 1'b1; wait_cyc(6);
      cs_n_pin = 1'b0; wait_cyc(6);
      clr_cnt();
      sck_pin = 1'b1; wait_cyc(4); sck_pin = 1'b0; wait_cyc(6);
      check("R8", "hold_active", hold_active, 0);
      check("R8", "edges forwarded", cnt_rise + cnt_fall, 2);

      hold_n_pin = 1'b1; cs_n_pin = 1'b1; wait_cyc(6);
      comparing = 1'b0;
      finish_run();
   end
endmodule